// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A controller programs a mode word through a load port. The word sets the burst length, the beat ordering and whether writes are limited to single beats. A start strobe then launches a burst at a given column. The block presents one column address per enabled clock, marks each beat valid and flags the final beat. It returns to idle at the end of the burst, on a stop request, or when a fresh start replaces the running burst.

The ordering runs only inside an aligned block whose size is the burst length. Sequential order counts upward from the start column and wraps at the block edge. Interleaved order XORs the start column with the beat index. The column bits above the block come from the start column and do not change. A full-page burst runs across the whole page, wraps around it, and has no final beat. A low clock-enable freezes the whole sequence. The block covers only address sequencing. Data transfer, read latency and bank handling belong to other logic.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset the block is idle: beat_valid=0, beat_last=0, col_addr=0 and cfg_err=0. The mode is burst length 1, sequential order, with writes using the programmed length.
- R2: Mode word bits [2:0] set the burst length: 000=1, 001=2, 010=4, 011=8, 111=full page (2^COL_W beats). Bit [3] picks the order: 0 is sequential and 1 is interleaved.
- R3: In sequential order, beat i has address (start & ~(L-1)) | ((start + i) mod L), where L is the burst length.
- R4: In interleaved order, beat i has address (start & ~(L-1)) | ((start ^ i) & (L-1)).
- R5: A full-page burst is sequential. Its address is (start + i) mod 2^COL_W, it never raises beat_last, and it runs until a stop or a new start.
- R6: When mode bit [9] is 1, a burst launched with start_write=1 is one beat long. A burst with start_write=0 still uses the programmed length.
- R7: beat_valid rises on the clock after an accepted start, and that beat shows start_col. beat_last is high only on the final beat of a finite burst. The clock after the final beat is idle unless a new start is accepted.
- R8: A stop accepted during a burst makes the block idle on the next clock, and col_addr holds its last value.
- R9: While cke=0, col_addr, beat_valid and beat_last hold their values, and start and stop are ignored.
- R10: A start accepted during a burst replaces it at once with the new column and the current mode. A start takes priority over a stop given in the same cycle.
- R11: A load is rejected, and cfg_err pulses for one clock, when any of these holds: the length code is 100, 101 or 110; the length is full page with interleaved order; bits [6:4] are neither 010 nor 011; bits [8:7] are nonzero; or any bit from [10] upward is nonzero. A rejected load keeps the previous mode.
- R12: A burst keeps the length and order it had at its start. A mode load during the burst affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Writes cfg_word into the mode register |
| cfg_word | input | MODE_W | Mode word (length, order, latency, test bits, write-single) |
| cfg_err | output | 1 | One-clock pulse after a rejected mode load |
| start | input | 1 | Launches a burst at start_col |
| start_write | input | 1 | The starting burst is a write |
| start_col | input | COL_W | First column of the burst |
| stop | input | 1 | Ends the running burst |
| cke | input | 1 | Clock enable; low freezes the sequence |
| col_addr | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is presented |
| beat_last | output | 1 | The current beat is the final one |

## Verification
The checker tests several rules on every clock:
- beat_last never appears without beat_valid.
- An enabled start yields a valid beat at the requested column.
- An enabled stop, or a completed last beat, leads to idle.
- A low clock enable freezes every output.
- A malformed mode load raises cfg_err, and cfg_err never rises without a load.

The actual beat orders can only be shown by the directed scenarios, because they depend on the start column and the captured mode. These include the sequential and interleaved wrap inside the block, the endless full-page wrap and single-beat writes. The scenarios also show the cases where the burst is resumed or replaced: resumption after a suspend, replacement by a new start, and the mode captured at start surviving a later load.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  localparam logic [2:0] LEN_CODE_PAGE = 3'b111;

  typedef struct packed {
    logic [2:0] len_code;
    logic       interleave;
    logic       wr_single;
  } burst_mode_t;

  function automatic logic len_code_ok(input logic [2:0] code, input logic il);
    case (code)
      3'b000, 3'b001, 3'b010, 3'b011: return 1'b1;
      3'b111:                         return !il;
      default:                        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import colgen_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output burst_mode_t       mode,
  output logic              err
);

  localparam int LEN_LO  = 0;
  localparam int TYPE_B  = 3;
  localparam int LAT_LO  = 4;
  localparam int TEST_LO = 7;
  localparam int WSGL_B  = 9;
  localparam int HI_LO   = 10;

  burst_mode_t cand;
  logic [2:0]  lat;
  logic [1:0]  test_bits;
  logic        word_ok;

  always_comb begin
    cand.len_code   = word[LEN_LO +: 3];
    cand.interleave = word[TYPE_B];
    cand.wr_single  = word[WSGL_B];
    lat             = word[LAT_LO +: 3];
    test_bits       = word[TEST_LO +: 2];
    word_ok = len_code_ok(cand.len_code, cand.interleave)
              && (lat == 3'b010 || lat == 3'b011)
              && (test_bits == 2'b00)
              && (word[MODE_W-1:HI_LO] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '{len_code: 3'b000, interleave: 1'b0, wr_single: 1'b0};
      err  <= 1'b0;
    end else begin
      err <= load && !word_ok;
      if (load && word_ok) mode <= cand;
    end
  end

endmodule

// File: rtl/colgen_order.sv
module colgen_order #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             interleave,
  output logic [COL_W-1:0] addr
);

  logic [COL_W-1:0] low_part;

  always_comb begin
    if (interleave) low_part = base ^ idx;
    else            low_part = base + idx;
    addr = (base & ~mask) | (low_part & mask);
  end

endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             start,
  input  logic             start_write,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  input  burst_mode_t      mode,
  output logic [COL_W-1:0] col_addr,
  output logic             beat_valid,
  output logic             beat_last
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             act_q, il_q, full_q;
  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic             act_n, il_n, full_n;
  logic [COL_W-1:0] base_n, idx_n, mask_n;
  logic [COL_W-1:0] start_mask;
  logic             single_wr;
  logic [COL_W-1:0] ord_addr;

  always_comb begin
    case (mode.len_code)
      3'b001:        start_mask = COL_W'(1);
      3'b010:        start_mask = COL_W'(3);
      3'b011:        start_mask = COL_W'(7);
      LEN_CODE_PAGE: start_mask = '1;
      default:       start_mask = '0;
    endcase
    single_wr = start_write && mode.wr_single;
  end

  always_comb begin
    act_n  = act_q;
    il_n   = il_q;
    full_n = full_q;
    base_n = base_q;
    idx_n  = idx_q;
    mask_n = mask_q;
    if (cke) begin
      if (start) begin
        act_n  = 1'b1;
        base_n = start_col;
        idx_n  = '0;
        mask_n = single_wr ? '0 : start_mask;
        il_n   = mode.interleave;
        full_n = !single_wr && (mode.len_code == LEN_CODE_PAGE);
      end else if (act_q) begin
        if (stop || beat_last) act_n = 1'b0;
        else                   idx_n = idx_q + ONE;
      end
    end
  end

  colgen_order #(.COL_W(COL_W)) u_order (
    .base       (base_n),
    .idx        (idx_n),
    .mask       (mask_n),
    .interleave (il_n),
    .addr       (ord_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= 1'b0;
      il_q       <= 1'b0;
      full_q     <= 1'b0;
      base_q     <= '0;
      idx_q      <= '0;
      mask_q     <= '0;
      col_addr   <= '0;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
    end else begin
      act_q      <= act_n;
      il_q       <= il_n;
      full_q     <= full_n;
      base_q     <= base_n;
      idx_q      <= idx_n;
      mask_q     <= mask_n;
      if (act_n) col_addr <= ord_addr;
      beat_valid <= act_n;
      beat_last  <= act_n && !full_n && (idx_n == mask_n);
    end
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [MODE_W-1:0] cfg_word,
  output logic              cfg_err,
  input  logic              start,
  input  logic              start_write,
  input  logic [COL_W-1:0]  start_col,
  input  logic              stop,
  input  logic              cke,
  output logic [COL_W-1:0]  col_addr,
  output logic              beat_valid,
  output logic              beat_last
);

  burst_mode_t mode;

  colgen_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk  (clk),
    .rst  (rst),
    .load (cfg_load),
    .word (cfg_word),
    .mode (mode),
    .err  (cfg_err)
  );

  colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cke         (cke),
    .start       (start),
    .start_write (start_write),
    .start_col   (start_col),
    .stop        (stop),
    .mode        (mode),
    .col_addr    (col_addr),
    .beat_valid  (beat_valid),
    .beat_last   (beat_last)
  );

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_load,
  input logic [MODE_W-1:0] cfg_word,
  input logic              cfg_err,
  input logic              start,
  input logic [COL_W-1:0]  start_col,
  input logic              stop,
  input logic              cke,
  input logic [COL_W-1:0]  col_addr,
  input logic              beat_valid,
  input logic              beat_last
);

  assert_last_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid);

  assert_last_then_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (beat_last && cke && !start) |=> !beat_valid);

  assert_start_column_R10: assert property (@(posedge clk) disable iff (rst)
    (cke && start) |=> (beat_valid && col_addr == $past(start_col)));

  assert_stop_idles_R8: assert property (@(posedge clk) disable iff (rst)
    (cke && stop && !start) |=> !beat_valid);

  assert_suspend_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(col_addr) && $stable(beat_valid) && $stable(beat_last)));

  assert_bad_len_flag_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_load && (cfg_word[2:0] inside {3'b100, 3'b101, 3'b110})) |=> cfg_err);

  assert_err_from_load_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(cfg_load));

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W), .MODE_W(MODE_W)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .cfg_load   (cfg_load),
  .cfg_word   (cfg_word),
  .cfg_err    (cfg_err),
  .start      (start),
  .start_col  (start_col),
  .stop       (stop),
  .cke        (cke),
  .col_addr   (col_addr),
  .beat_valid (beat_valid),
  .beat_last  (beat_last)
);

// File: tb/test_sdram_burst_colgen.sv
`timescale 1ns/1ps
module test_sdram_burst_colgen;

  localparam int COL_W  = 8;
  localparam int MODE_W = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_load = 1'b0;
  logic [MODE_W-1:0] cfg_word = '0;
  logic              cfg_err;
  logic              start = 1'b0;
  logic              start_write = 1'b0;
  logic [COL_W-1:0]  start_col = '0;
  logic              stop = 1'b0;
  logic              cke = 1'b1;
  logic [COL_W-1:0]  col_addr;
  logic              beat_valid;
  logic              beat_last;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W), .MODE_W(MODE_W)) i_sdram_burst_colgen (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word), .cfg_err(cfg_err),
    .start(start), .start_write(start_write), .start_col(start_col), .stop(stop),
    .cke(cke), .col_addr(col_addr), .beat_valid(beat_valid), .beat_last(beat_last)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int base, input int idx, input int len, input bit il);
    int m = len - 1;
    int lo = il ? ((base ^ idx) & m) : ((base + idx) & m);
    return (base & ~m & 8'hFF) | lo;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic prog(input int word);
    cfg_load = 1'b1;
    cfg_word = MODE_W'(word);
    tick();
    cfg_load = 1'b0;
  endtask

  task automatic go(input int col, input bit wr);
    start = 1'b1;
    start_write = wr;
    start_col = COL_W'(col);
    tick();
    start = 1'b0;
    start_write = 1'b0;
  endtask

  task automatic expect_burst(input string req, input int base, input int len,
                              input bit il, input int first);
    for (int i = first; i < len; i++) begin
      check({req, " addr"}, int'(col_addr), exp_addr(base, i, len, il));
      check({req, " valid"}, int'(beat_valid), 1);
      check({req, " last"}, int'(beat_last), (i == len - 1) ? 1 : 0);
      tick();
    end
    check({req, " idle after burst"}, int'(beat_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 valid", int'(beat_valid), 0);
    check("R1 last", int'(beat_last), 0);
    check("R1 addr", int'(col_addr), 0);
    check("R1 err", int'(cfg_err), 0);
    go(8'h37, 1'b0);
    expect_burst("R1 default single", 8'h37, 1, 1'b0, 0);
  endtask

  task automatic t_seq();
    prog(12'h022);
    check("R11 good load no err", int'(cfg_err), 0);
    go(8'h12, 1'b0);
    expect_burst("R3 seq len4", 8'h12, 4, 1'b0, 0);
    prog(12'h021);
    go(8'h09, 1'b0);
    expect_burst("R2 seq len2", 8'h09, 2, 1'b0, 0);
    prog(12'h033);
    go(8'h4E, 1'b0);
    expect_burst("R3 seq len8", 8'h4E, 8, 1'b0, 0);
  endtask

  task automatic t_interleave();
    prog(12'h02B);
    go(8'h25, 1'b0);
    check("R4 second beat xor", exp_addr(8'h25, 1, 8, 1'b1), 8'h24);
    expect_burst("R4 il len8", 8'h25, 8, 1'b1, 0);
    prog(12'h02A);
    go(8'h63, 1'b0);
    expect_burst("R4 il len4", 8'h63, 4, 1'b1, 0);
  endtask

  task automatic t_full_page();
    int last_seen;
    prog(12'h027);
    go(8'hFE, 1'b0);
    for (int i = 0; i < 300; i++) begin
      check("R5 page addr", int'(col_addr), (8'hFE + i) & 8'hFF);
      check("R5 page no last", int'(beat_last), 0);
      tick();
    end
    last_seen = int'(col_addr);
    stop = 1'b1;
    tick();
    stop = 1'b0;
    check("R8 stop idles page", int'(beat_valid), 0);
    check("R8 addr held", int'(col_addr), last_seen);
  endtask

  task automatic t_single_write();
    prog(12'h222);
    go(8'h40, 1'b1);
    expect_burst("R6 write single", 8'h40, 1, 1'b0, 0);
    go(8'h41, 1'b0);
    expect_burst("R6 read keeps len4", 8'h41, 4, 1'b0, 0);
    prog(12'h022);
    go(8'h41, 1'b1);
    expect_burst("R6 write programmed", 8'h41, 4, 1'b0, 0);
  endtask

  task automatic t_stop();
    prog(12'h033);
    go(8'h10, 1'b0);
    check("R7 first beat", int'(col_addr), 8'h10);
    tick();
    check("R3 second beat", int'(col_addr), 8'h11);
    stop = 1'b1;
    tick();
    stop = 1'b0;
    check("R8 stop valid", int'(beat_valid), 0);
    check("R8 stop addr held", int'(col_addr), 8'h11);
  endtask

  task automatic t_suspend();
    prog(12'h033);
    go(8'h30, 1'b0);
    cke = 1'b0;
    start = 1'b1;
    start_col = 8'hAA;
    stop = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R9 frozen addr", int'(col_addr), 8'h30);
      check("R9 frozen valid", int'(beat_valid), 1);
      check("R9 frozen last", int'(beat_last), 0);
    end
    cke = 1'b1;
    start = 1'b0;
    stop = 1'b0;
    tick();
    expect_burst("R9 resumed", 8'h30, 8, 1'b0, 1);
    cke = 1'b0;
    start = 1'b1;
    start_col = 8'h55;
    tick();
    check("R9 start ignored idle", int'(beat_valid), 0);
    cke = 1'b1;
    start = 1'b0;
  endtask

  task automatic t_interrupt();
    prog(12'h033);
    go(8'h50, 1'b0);
    tick();
    check("R10 before interrupt", int'(col_addr), 8'h51);
    start = 1'b1;
    start_col = 8'h64;
    stop = 1'b1;
    tick();
    start = 1'b0;
    stop = 1'b0;
    expect_burst("R10 replaced burst", 8'h64, 8, 1'b0, 0);
  endtask

  task automatic t_reserved();
    prog(12'h022);
    prog(12'h025);
    check("R11 reserved len err", int'(cfg_err), 1);
    tick();
    check("R11 err one clock", int'(cfg_err), 0);
    prog(12'h02F);
    check("R11 page interleave err", int'(cfg_err), 1);
    prog(12'h042);
    check("R11 latency err", int'(cfg_err), 1);
    prog(12'h0A2);
    check("R11 test bits err", int'(cfg_err), 1);
    prog(12'h422);
    check("R11 high bits err", int'(cfg_err), 1);
    go(8'h71, 1'b0);
    expect_burst("R11 mode kept", 8'h71, 4, 1'b0, 0);
  endtask

  task automatic t_capture();
    prog(12'h033);
    go(8'h80, 1'b0);
    check("R12 first beat", int'(col_addr), 8'h80);
    prog(12'h028);
    expect_burst("R12 burst keeps len8", 8'h80, 8, 1'b0, 1);
    go(8'h85, 1'b0);
    expect_burst("R12 next burst il len1", 8'h85, 1, 1'b1, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_seq();
    t_interleave();
    t_full_page();
    t_single_write();
    t_stop();
    t_suspend();
    t_interrupt();
    t_reserved();
    t_capture();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule